// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state. A pulse on `start` captures the timing and mode settings, raises the clock-enable pin, and holds NOP on the command pins for a stabilization delay of at least 200 microseconds. The delay is counted in cycles from clock-frequency and delay parameters. The block then issues one precharge-all command and a burst of eight auto-refresh commands. Last comes one load-mode-register command whose address word carries the CAS latency and the burst-length code. Required gaps of idle cycles separate these commands.

Once the mode register is loaded and its settle time has passed, `done` goes high and stays high. From then on a free-running refresh timer pulses `ref_req` once per programmed period. A downstream controller uses that pulse to schedule auto-refresh commands. During normal operation the command pins rest at NOP, so the block can be multiplexed with the main controller's command path.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in idle before any start, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111, `ba` and `addr` are 0, and `done` and `ref_req` are 0.
- R2: The cycle after `start` is sampled, `cke` goes to 1 and stays 1. NOP is driven for exactly STAB_CYC = CLK_MHZ*STAB_US cycles (20000 by default) before the first command.
- R3: The first command is a single-cycle precharge-all, encoded 4'b0010 with `addr` bit 10 set and every other address bit 0.
- R4: Eight auto-refresh commands (4'b0001) follow. The first comes tRP cycles after the precharge, and each later one comes tRC cycles after the previous one.
- R5: tRC cycles after the eighth refresh, one load-mode command (4'b0000) is issued. Its `addr` has burst code in bits 2:0, bit 3 = 0, CAS latency in bits 6:4 and zeros above, and `ba` = 0.
- R6: `done` rises exactly 2 cycles after the load-mode command and stays high. NOP is driven in every cycle that carries no command.
- R7: Once `done` is high, `ref_req` is a one-cycle pulse. The first pulse comes P-1 cycles after the first `done` cycle, and later pulses come every P cycles. P is the value on `ref_period`, read at each reload.
- R8: A value of 0 for tRP, tRC or the refresh period behaves as 1.
- R9: tRP, tRC, CAS latency and burst code are captured when `start` is accepted. Later changes on those inputs have no effect on the running sequence.
- R10: A `start` pulse that arrives while the sequence is running or done is ignored and does not shift any command.
- R11: Asserting reset in the middle of the sequence returns the block to idle with `cke` at 0, and it stays there until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence (accepted only in idle) |
| cfg_trp | input | 4 | Precharge-to-command gap, cycles |
| cfg_trc | input | 4 | Refresh-to-command gap, cycles |
| cfg_cas | input | 3 | CAS latency written to the mode register |
| cfg_burst | input | 3 | Burst-length code written to the mode register |
| ref_period | input | REF_W (16) | Refresh request interval, cycles |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W (2) | Bank address |
| addr | output | ADDR_W (13) | Address / mode word |
| done | output | 1 | Initialization complete |
| ref_req | output | 1 | Periodic auto-refresh request pulse |

## Verification
Every internal counter in this block leads straight to a cycle position on the command pins. A stabilization count that is off by one moves the precharge by one cycle, about 200 microseconds after start. A wrong refresh index changes the number of 4'b0001 cycles, and the load-mode command then moves by a whole tRC. A wrong wait-counter load changes the gap between two commands the first time that gap occurs. A refresh timer with a bad reload value changes the `ref_req` spacing within the first period after `done`. The bench therefore compares every output in every cycle against a schedule computed from the captured settings. Any drift is caught in the first cycle where it appears.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int TIM_W     = 4;
    localparam int CAS_W     = 3;
    localparam int BL_W      = 3;
    localparam int MRD_CYC   = 2;
    localparam int REF_BURST = 8;
    localparam int A10_BIT   = 10;
    localparam int MODE_W    = BL_W + 1 + CAS_W;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAB,
        S_PRE,
        S_REF,
        S_LMR,
        S_WAIT,
        S_RUN
    } state_e;

    typedef struct packed {
        logic [TIM_W-1:0] trp;
        logic [TIM_W-1:0] trc;
        logic [CAS_W-1:0] cas;
        logic [BL_W-1:0]  bl;
    } init_cfg_t;

    function automatic logic [TIM_W-1:0] at_least_one(input logic [TIM_W-1:0] v);
        return (v == '0) ? TIM_W'(1) : v;
    endfunction

    function automatic logic [MODE_W-1:0] mode_word(input logic [CAS_W-1:0] cas,
                                                    input logic [BL_W-1:0] bl);
        return {cas, 1'b0, bl};
    endfunction

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int STAB_CYC = 20000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  init_cfg_t cfg_in,
    output init_cfg_t cfg_q,
    output cmd_e      cmd,
    output logic      cke,
    output logic      run
);
    localparam int STAB_W = $clog2(STAB_CYC + 1);
    localparam int RC_W   = $clog2(REF_BURST);

    state_e            state, ret;
    logic [STAB_W-1:0] scnt;
    logic [TIM_W-1:0]  wcnt;
    logic [RC_W-1:0]   rcnt;
    logic [TIM_W-1:0]  gap;
    state_e            tgt;

    always_comb begin
        gap = TIM_W'(1);
        tgt = S_IDLE;
        case (state)
            S_PRE: begin
                gap = at_least_one(cfg_q.trp);
                tgt = S_REF;
            end
            S_REF: begin
                gap = at_least_one(cfg_q.trc);
                tgt = (rcnt == RC_W'(REF_BURST - 1)) ? S_LMR : S_REF;
            end
            S_LMR: begin
                gap = TIM_W'(MRD_CYC);
                tgt = S_RUN;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ret   <= S_IDLE;
            scnt  <= '0;
            wcnt  <= '0;
            rcnt  <= '0;
            cke   <= 1'b0;
            cfg_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    cfg_q <= cfg_in;
                    cke   <= 1'b1;
                    scnt  <= STAB_W'(STAB_CYC - 1);
                    state <= S_STAB;
                end
                S_STAB: begin
                    if (scnt == '0) state <= S_PRE;
                    else            scnt  <= scnt - 1'b1;
                end
                S_PRE, S_REF, S_LMR: begin
                    if (state == S_PRE)      rcnt <= '0;
                    else if (state == S_REF) rcnt <= rcnt + 1'b1;
                    if (gap <= TIM_W'(1)) begin
                        state <= tgt;
                    end else begin
                        state <= S_WAIT;
                        wcnt  <= gap - TIM_W'(2);
                        ret   <= tgt;
                    end
                end
                S_WAIT: begin
                    if (wcnt == '0) state <= ret;
                    else            wcnt  <= wcnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            S_PRE:   cmd = CMD_PRE;
            S_REF:   cmd = CMD_REF;
            S_LMR:   cmd = CMD_LMR;
            default: cmd = CMD_NOP;
        endcase
    end

    assign run = (state == S_RUN);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [REF_W-1:0] period,
    output logic             req
);
    logic [REF_W-1:0] tmr;
    logic [REF_W-1:0] load;

    assign load = (period == '0) ? '0 : period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run)      tmr <= load;
        else if (tmr == '0)   tmr <= load;
        else                  tmr <= tmr - 1'b1;
    end

    assign req = run && (tmr == '0);

endmodule

// File: rtl/sdram_pin_encode.sv
module sdram_pin_encode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  cmd_e              cmd,
    input  logic [CAS_W-1:0]  cas,
    input  logic [BL_W-1:0]   bl,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba = '0;

    always_comb begin
        addr = '0;
        case (cmd)
            CMD_PRE: addr[A10_BIT] = 1'b1;
            CMD_LMR: addr = ADDR_W'(mode_word(cas, bl));
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int STAB_US = 200,
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int REF_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trc,
    input  logic [2:0]        cfg_cas,
    input  logic [2:0]        cfg_burst,
    input  logic [REF_W-1:0]  ref_period,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              ref_req
);
    localparam int STAB_CYC = CLK_MHZ * STAB_US;

    init_cfg_t cfg_in, cfg_q;
    cmd_e      cmd;
    logic      run;

    assign cfg_in = '{trp: cfg_trp, trc: cfg_trc, cas: cfg_cas, bl: cfg_burst};

    sdram_init_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .cmd    (cmd),
        .cke    (cke),
        .run    (run)
    );

    sdram_refresh_timer #(.REF_W(REF_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .period (ref_period),
        .req    (ref_req)
    );

    sdram_pin_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .cmd   (cmd),
        .cas   (cfg_q.cas),
        .bl    (cfg_q.bl),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    assign done = run;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done,
    input logic              ref_req
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (pins == 4'b0111 && !done && !ref_req));

    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_pre_a10_r3: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> addr[10]);

    p_lmr_bank0_r5: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> (ba == '0 && !addr[3]));

    p_lmr_to_done_r6: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |=> !done ##1 done);

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && pins == 4'b0111));

    p_req_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> done);

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .done    (done),
    .ref_req (ref_req)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

    localparam int N = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  cfg_trp = '0, cfg_trc = '0;
    logic [2:0]  cfg_cas = '0, cfg_burst = '0;
    logic [15:0] ref_period = 16'd10;
    logic        cke, cs_n, ras_n, cas_n, we_n, done, ref_req;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdram_init_seq u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_cas(cfg_cas), .cfg_burst(cfg_burst),
        .ref_period(ref_period),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done), .ref_req(ref_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // {cke, cmd[3:0], ba[1:0], addr[12:0], done}
    function automatic logic [20:0] obs();
        return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({obs(), ref_req} == 22'h0E0000, "R1 outputs under reset", 32'({obs(), ref_req}), 32'h0E0000);
        rst = 1'b0;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if ({obs(), ref_req} != 22'h0E0000) bad++;
            end
            chk(bad == 0, "R1 idle holds without start", 32'(bad), 0);
        end
    endtask

    task automatic run_seq(input int trp, input int trc, input int cas, input int bl,
                           input int per, input bit poke, input string rtag);
        int etrp, etrc, lmr, d, p, tend;
        int err[6];
        logic [31:0] fa[6], fe[6];
        string ctag[6];
        ctag = '{"R2 stabilization", "R3 precharge", "R4 refresh burst",
                 "R5 mode load", "R6 done/nop", "R7 refresh request"};
        for (int c = 0; c < 6; c++) begin err[c] = 0; fa[c] = 0; fe[c] = 0; end
        etrp = eff(trp); etrc = eff(trc); p = eff(per);
        lmr  = N + etrp + 8 * etrc;
        d    = lmr + 2;
        tend = d + 3 * p + 2;
        cfg_trp = 4'(trp); cfg_trc = 4'(trc); cfg_cas = 3'(cas); cfg_burst = 3'(bl);
        ref_period = 16'(per);
        @(negedge clk);
        start = 1'b1;
        for (int t = 0; t <= tend; t++) begin
            logic [3:0]  ecmd;
            logic [12:0] eaddr;
            logic        edone, ereq;
            logic [20:0] ev;
            int          cat;
            @(negedge clk);
            ecmd = 4'b0111; eaddr = '0;
            edone = (t >= d);
            ereq  = (t >= d) && (((t - d) % p) == p - 1);
            if (t == N) begin ecmd = 4'b0010; eaddr = 13'h400; end
            else if (t == lmr) begin ecmd = 4'b0000; eaddr = 13'({3'(cas), 1'b0, 3'(bl)}); end
            else if (t > N && t < lmr && (t - N - etrp) >= 0 && ((t - N - etrp) % etrc) == 0)
                ecmd = 4'b0001;
            ev = {1'b1, ecmd, 2'b00, eaddr, edone};
            if (t < N) cat = 0;
            else if (t == N) cat = 1;
            else if (t < lmr) cat = 2;
            else if (t == lmr) cat = 3;
            else cat = 4;
            if (obs() != ev) begin
                if (err[cat] == 0) begin fa[cat] = 32'(obs()); fe[cat] = 32'(ev); end
                err[cat]++;
            end
            if (ref_req != ereq) begin
                if (err[5] == 0) begin fa[5] = {31'(t), ref_req}; fe[5] = {31'(t), ereq}; end
                err[5]++;
            end
            // stimulus for the next cycle
            start = 1'b0;
            if (poke) begin
                if (t == 5 || t == N + etrp + 2 || t == d + 1) start = 1'b1;
                if (t == 10) begin
                    cfg_trp = 4'd5; cfg_trc = 4'd9; cfg_cas = 3'd7; cfg_burst = 3'd7;
                end
            end
        end
        for (int c = 0; c < 6; c++)
            chk(err[c] == 0, {ctag[c], " ", rtag}, fa[c], fe[c]);
    endtask

    task automatic test_mid_reset();
        cfg_trp = 4'd2; cfg_trc = 4'd3;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        chk(cke == 1'b1, "R11 cke high before reset", 32'(cke), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({obs(), ref_req} == 22'h0E0000, "R11 idle right after reset", 32'({obs(), ref_req}), 32'h0E0000);
        begin
            int bad = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (cke != 1'b0 || done != 1'b0) bad++;
            end
            chk(bad == 0, "R11 stays idle after reset", 32'(bad), 0);
        end
    endtask

    initial begin
        test_reset_idle();
        run_seq(3, 7, 3, 3, 50, 1'b0, "base");
        do_reset();
        run_seq(0, 0, 2, 0, 0, 1'b1, "R8 R9 R10 zeros+pokes");
        do_reset();
        run_seq(15, 15, 2, 7, 2, 1'b0, "max gaps");
        do_reset();
        test_mid_reset();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule